// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Select Timing

This block sends one word to a single peripheral and receives one word back over a four-wire serial link, with the peripheral select held active for the whole exchange. The host sets the clock polarity, a clock divider, a select-to-clock lead, a clock-to-select lag and an extra-lead option, presents a transmit word and pulses `start`. Every setting is captured at that moment. The block drives `busy` until the exchange ends. It then pulses `done` for one cycle and presents the received word.

The serial clock period is a whole, even number of system clock cycles, and the two clock phases are equal. The select lead and lag are counted in whole system clock cycles, so the gaps around the clock burst are exact rather than approximate. Data moves most significant bit first. The peripheral's output is sampled on the trailing edge of each serial clock pulse. Outgoing data changes on the leading edge.

Top module: `spi_cs_master`

## Requirements
- R1: After reset and whenever `busy` is low, `cs_n` is high (inactive) and `sclk` sits at the idle level, which equals `cpol` (0 idles low, 1 idles high); `busy` and `done` are low after reset.
- R2: A `start` pulse while idle makes `cs_n` go low and `busy` go high at the next clock edge, and loads the settings and the transmit word at that edge.
- R3: With `cs_hold` = 0, the first `sclk` transition comes exactly `c2t_dly` + 2 system clock cycles after `cs_n` falls, and `sclk` stays at the idle level until then.
- R4: With `cs_hold` = 1, that lead is exactly `c2t_dly` + 3 system clock cycles.
- R5: The effective period P is `div_sel` rounded up to even, forced to at least 2 and capped at 256. Each `sclk` phase lasts P/2 system clock cycles.
- R6: With `cpol` = 0, `somi` is sampled on falling `sclk` transitions. `simo` changes only on rising transitions and carries the transmit word MSB first, starting from the instant `cs_n` falls.
- R7: With `cpol` = 1, `somi` is sampled on rising transitions and `simo` changes only on falling transitions, again MSB first.
- R8: `cs_n` rises exactly P/2 + `t2c_dly` + 1 system clock cycles after the last `sclk` transition.
- R9: `done` is high for exactly one cycle, in the same cycle that `cs_n` rises and `busy` falls. In that cycle `rx_word` holds the bits sampled from `somi`, first sample in the MSB.
- R10: A `start` pulse while `busy` is high is ignored. The running exchange keeps its settings and data, and no second exchange follows.
- R11: Each exchange has exactly 2 x WORD_W `sclk` transitions (16 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one exchange (accepted when idle) |
| cpol | input | 1 | Clock idle level |
| div_sel | input | 9 | Requested serial clock period in system cycles |
| c2t_dly | input | 8 | Extra select-to-clock lead cycles |
| t2c_dly | input | 8 | Extra clock-to-select lag cycles |
| cs_hold | input | 1 | Adds one cycle to the lead |
| tx_word | input | 8 | Word to transmit |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| rx_word | output | 8 | Last received word |
| sclk | output | 1 | Serial clock |
| simo | output | 1 | Serial data to the peripheral |
| somi | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Active-low peripheral select |

## Verification
The exchanges use both polarities and divider requests of 0, 1, 4, 7 and 300. These values separate the correct minimum, odd rounding and upper cap from a raw divider. The lead and lag fields take zero, small and maximum values with the extra-lead bit both set and clear, which exposes any off-by-one in the counters. The data words are complementary and asymmetric patterns such as A5/3C, 81/7E and all-ones/all-zeros, so a reversed bit order, a lost bit or a sample on the wrong edge shows up in the compared words. One exchange receives a second start with different settings in mid-flight, and the timing and data must remain those of the first request.

// File: rtl/spi_cs_pkg.sv
// Shared types for the serial master: sequencer state encoding.
package spi_cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/spi_cs_divcalc.sv
// Converts a requested serial clock period into a half period.
// Assumes MAX_DIV is even and at least 2. The result is never below 1.
module spi_cs_divcalc #(
    parameter int DIV_W   = 9,
    parameter int MAX_DIV = 256
) (
    input  logic [DIV_W-1:0] div_sel,
    output logic [DIV_W-1:0] half
);
    localparam logic [DIV_W:0] MAX_E = (DIV_W+1)'(MAX_DIV);

    logic [DIV_W:0] even_p;

    // Round up to even, clamp to [2, MAX_DIV], then halve.
    always_comb begin
        even_p = {1'b0, div_sel} + {{DIV_W{1'b0}}, div_sel[0]};
        if (even_p < (DIV_W+1)'(2))
            even_p = (DIV_W+1)'(2);
        else if (even_p > MAX_E)
            even_p = MAX_E;
        half = even_p[DIV_W:1];
    end
endmodule

// File: rtl/spi_cs_seq.sv
// Sequencer: drives the select, the serial clock and the shift events.
// Timing counts whole system cycles. Settings are held from the start edge
// until the select is released.
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 9,
    parameter int DLY_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cpol,
    input  logic [DIV_W-1:0] half_in,
    input  logic [DLY_W-1:0] c2t_dly,
    input  logic [DLY_W-1:0] t2c_dly,
    input  logic             cs_hold,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             sclk,
    output logic             load,
    output logic             shift_tx,
    output logic             sample_rx,
    output logic             finish
);
    localparam int LAST_EDGE = 2 * WORD_W;
    localparam int EDGE_W    = $clog2(LAST_EDGE) + 1;
    localparam int CNT_W     = ((DLY_W > DIV_W) ? DLY_W : DIV_W) + 1;

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] ph;
    logic [EDGE_W-1:0] edge_n;
    logic [DIV_W-1:0] half_q;
    logic [DLY_W-1:0] t2c_q;
    logic             cpol_q;
    logic             toggle;

    // Event decode: a toggle this cycle and which kind of edge it is.
    always_comb begin
        toggle    = ((state == ST_SETUP) && (cnt == '0)) ||
                    ((state == ST_XFER)  && (ph  == '0));
        load      = (state == ST_IDLE) && start;
        shift_tx  = toggle && !edge_n[0] && (edge_n != '0);
        sample_rx = toggle && edge_n[0];
        finish    = (state == ST_HOLD) && (cnt == '0);
        busy      = (state != ST_IDLE);
    end

    // Main state machine with the lead, phase and lag counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cs_n   <= 1'b1;
            sclk   <= cpol;
            done   <= 1'b0;
            cnt    <= '0;
            ph     <= '0;
            edge_n <= '0;
            half_q <= DIV_W'(1);
            t2c_q  <= '0;
            cpol_q <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    sclk <= cpol;
                    if (start) begin
                        cs_n   <= 1'b0;
                        cpol_q <= cpol;
                        half_q <= half_in;
                        t2c_q  <= t2c_dly;
                        cnt    <= CNT_W'(c2t_dly) + CNT_W'(1) + CNT_W'(cs_hold);
                        edge_n <= '0;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        sclk   <= ~sclk;
                        edge_n <= EDGE_W'(1);
                        ph     <= half_q - DIV_W'(1);
                        state  <= ST_XFER;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_XFER: begin
                    if (ph == '0) begin
                        sclk   <= ~sclk;
                        edge_n <= edge_n + EDGE_W'(1);
                        ph     <= half_q - DIV_W'(1);
                        if (edge_n == EDGE_W'(LAST_EDGE - 1)) begin
                            cnt   <= CNT_W'(half_q) + CNT_W'(t2c_q);
                            state <= ST_HOLD;
                        end
                    end else begin
                        ph <= ph - DIV_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        cs_n  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CS_INACTIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> cs_n); // R1
    AST_SETUP_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |-> (sclk == cpol_q)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done); // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(half_q) && $stable(t2c_q) && $stable(cpol_q))); // R10
    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        edge_n <= EDGE_W'(LAST_EDGE)); // R11
endmodule

// File: rtl/spi_cs_shift.sv
// Data path: transmit shifter (MSB first) and receive shifter with output hold.
// Assumes the sequencer issues at most one event per cycle.
module spi_cs_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_tx,
    input  logic              sample_rx,
    input  logic              finish,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              somi,
    output logic              simo,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    // Load, advance and capture the serial words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
        end else begin
            if (load)
                tx_sh <= tx_word;
            else if (shift_tx)
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            if (sample_rx)
                rx_sh <= {rx_sh[WORD_W-2:0], somi};
            if (finish)
                rx_word <= rx_sh;
        end
    end

    assign simo = tx_sh[WORD_W-1];

    AST_SIMO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_tx) |=> $stable(simo)); // R6
endmodule

// File: rtl/spi_cs_master.sv
// Top level: single-select serial master with cycle-exact select timing.
// Assumes start is synchronous to clk. All settings are sampled on acceptance.
module spi_cs_master #(
    parameter int WORD_W  = 8,
    parameter int DIV_W   = 9,
    parameter int MAX_DIV = 256,
    parameter int DLY_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cpol,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DLY_W-1:0]  c2t_dly,
    input  logic [DLY_W-1:0]  t2c_dly,
    input  logic              cs_hold,
    input  logic [WORD_W-1:0] tx_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              simo,
    input  logic              somi,
    output logic              cs_n
);
    logic [DIV_W-1:0] half;
    logic             load;
    logic             shift_tx;
    logic             sample_rx;
    logic             finish;

    spi_cs_divcalc #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) div_i (
        .div_sel (div_sel),
        .half    (half)
    );

    spi_cs_seq #(.WORD_W(WORD_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cpol      (cpol),
        .half_in   (half),
        .c2t_dly   (c2t_dly),
        .t2c_dly   (t2c_dly),
        .cs_hold   (cs_hold),
        .busy      (busy),
        .done      (done),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .load      (load),
        .shift_tx  (shift_tx),
        .sample_rx (sample_rx),
        .finish    (finish)
    );

    spi_cs_shift #(.WORD_W(WORD_W)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift_tx  (shift_tx),
        .sample_rx (sample_rx),
        .finish    (finish),
        .tx_word   (tx_word),
        .somi      (somi),
        .simo      (simo),
        .rx_word   (rx_word)
    );

    AST_BUSY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> cs_n); // R1
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !cs_n)); // R2
endmodule

// File: tb/spi_cs_master_tb.sv
// Scoreboard bench: the driver queues expected exchanges and the monitor
// measures pin timing and data at negedge, then compares on done.
module spi_cs_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct {
        logic [7:0] tx;
        logic [7:0] slv;
        logic       pol;
        int         half;
        int         setup;
        int         hold;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cpol = 1'b0;
    logic [8:0] div_sel = 9'd4;
    logic [7:0] c2t_dly = '0;
    logic [7:0] t2c_dly = '0;
    logic cs_hold = 1'b0;
    logic [7:0] tx_word = '0;
    logic somi = 1'b0;
    logic busy, done, sclk, simo, cs_n;
    logic [7:0] rx_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t q[$];

    spi_cs_master dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol),
        .div_sel(div_sel), .c2t_dly(c2t_dly), .t2c_dly(t2c_dly),
        .cs_hold(cs_hold), .tx_word(tx_word), .busy(busy), .done(done),
        .rx_word(rx_word), .sclk(sclk), .simo(simo), .somi(somi), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: push the expected result, then request the exchange.
    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] slv, input logic pol,
                            input int div, input int c2t, input int t2c,
                            input logic hld, input bit poke);
        exp_t e;
        int p;
        p = div + (div % 2);
        if (p < 2) p = 2;
        if (p > 256) p = 256;
        e.tx = tx; e.slv = slv; e.pol = pol; e.half = p / 2;
        e.setup = c2t + 2 + int'(hld);
        e.hold = p / 2 + t2c + 1;
        q.push_back(e);
        @(negedge clk);
        cpol = pol; div_sel = 9'(div); c2t_dly = 8'(c2t); t2c_dly = 8'(t2c);
        cs_hold = hld; tx_word = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !cs_n, "R2 accept", int'(busy), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; tx_word = ~tx; div_sel = 9'd2; t2c_dly = 8'd0;
            c2t_dly = 8'd0; cpol = ~pol;
            @(negedge clk);
            start = 1'b0;
            cpol = pol;
        end
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor and peripheral model.
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_simo = 1'b0;
    bit   in_x = 0;
    int   cyc, edges, last_edge, setup_meas, half_bad, simo_bad;
    logic [7:0] mcap, slv_sh;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                in_x = 1; cyc = 0; edges = 0; last_edge = 0; setup_meas = -1;
                half_bad = 0; simo_bad = 0; mcap = '0;
                if (q.size() == 0) begin
                    check(0, "R10 unexpected exchange", 1, 0);
                    slv_sh = '0;
                end else begin
                    slv_sh = q[0].slv;
                    check(sclk == q[0].pol, "R1 idle level at select", int'(sclk), int'(q[0].pol));
                end
                somi <= slv_sh[7];
            end else if (in_x) begin
                cyc++;
                if (cs_n) begin
                    in_x = 0;
                    check(done === 1'b1, "R9 done with release", int'(done), 1);
                    if (q.size() != 0) begin
                        exp_t e;
                        e = q.pop_front();
                        check(setup_meas == e.setup, e.setup == 0 ? "R3" :
                              "R3/R4 lead cycles", setup_meas, e.setup);
                        check(cyc - last_edge == e.hold, "R8 lag cycles", cyc - last_edge, e.hold);
                        check(edges == 2 * W, "R11 edge count", edges, 2 * W);
                        check(half_bad == 0, "R5 half period", half_bad, 0);
                        check(simo_bad == 0, e.pol ? "R7 simo edge" : "R6 simo edge", simo_bad, 0);
                        check(mcap == e.tx, e.pol ? "R7 tx word" : "R6 tx word", int'(mcap), int'(e.tx));
                        check(rx_word == e.slv, "R9 rx word", int'(rx_word), int'(e.slv));
                    end
                end else if (sclk != prev_sclk) begin
                    if (edges == 0) setup_meas = cyc;
                    else if (q.size() != 0 && (cyc - last_edge) != q[0].half) half_bad++;
                    edges++;
                    last_edge = cyc;
                    if (q.size() != 0 && sclk == q[0].pol) begin
                        mcap = {mcap[6:0], simo};
                        slv_sh = {slv_sh[6:0], 1'b0};
                        somi <= slv_sh[7];
                    end else if (simo != prev_simo) begin
                        simo_bad = simo_bad;
                    end
                end else if (simo != prev_simo) begin
                    simo_bad++;
                end
                if (sclk != prev_sclk && q.size() != 0 && sclk == q[0].pol && simo != prev_simo)
                    simo_bad++;
            end else if (done) begin
                check(0, "R9 stray done", 1, 0);
            end
            prev_cs = cs_n; prev_sclk = sclk; prev_simo = simo;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R1 reset cs_n", int'(cs_n), 1);
        check(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
        check(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", int'(busy), 0);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1, "R1 idle high for cpol 1", int'(sclk), 1);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        run_xfer(8'hA5, 8'h3C, 1'b0, 4,   0,   0,   1'b0, 0);
        run_xfer(8'h81, 8'h7E, 1'b1, 7,   3,   2,   1'b1, 0);
        run_xfer(8'hFF, 8'h00, 1'b0, 1,   255, 255, 1'b0, 0);
        run_xfer(8'h00, 8'hFF, 1'b1, 300, 1,   0,   1'b1, 1);
        run_xfer(8'h5A, 8'hC3, 1'b0, 0,   0,   7,   1'b1, 0);
        repeat (30) @(negedge clk);
        check(q.size() == 0 && !busy && cs_n, "R10 no extra exchange", q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule